// File: doc/BRIEF.md
# Input Change Notification Unit

This block watches a bank of digital input pins and raises one interrupt flag when any pin whose enable bit is set changes level, in either direction. Each pin is first brought through a synchronizer chain. Its level is then compared with a stored reference that is refreshed on every sample, so a single transition produces a single flag event. The whole unit runs on a free-running low-speed clock. Detection therefore keeps working while the processor's main clock is stopped. If a change is seen while the sleep input is high, a wake output is raised together with the flag.

The block also drives the weak pull-up and pull-down controls for each pad. These controls are forced off for any pin whose direction bit marks it as an output, and the block never turns both on for the same pin. If software asks for both on one pin, the pull-up wins and a sticky configuration-error flag is set. Software clears the interrupt flag with a one-cycle clear pulse, which stands for a write-one-to-clear access.

Top module: `cn_notify`

## Requirements
- R1: After reset the flag, wake and configuration-error outputs are 0. Pin levels that are already present when reset is released never set the flag.
- R2: When an enabled pin goes from 0 to 1, the flag rises exactly SYNC_STAGES+1 clock edges after the new level is applied. It is still 0 after SYNC_STAGES edges.
- R3: When an enabled pin goes from 1 to 0, the flag is set with the same latency as in R2.
- R4: A change on a pin whose enable bit is 0 never sets the flag.
- R5: The flag stays set until a clear pulse. A clear pulse that does not coincide with a change clears the flag on the next edge. If a change is detected on the same edge as the clear, the flag stays set.
- R6: One transition produces one flag event. After the flag is cleared, a pin that holds its new level does not set the flag again.
- R7: Clearing an enable bit does not clear a flag that is already pending.
- R8: A change detected while sleep is 1 raises the wake output on the same edge as the flag. Wake stays up while sleep stays 1 and falls on the first edge with sleep at 0. A change detected with sleep at 0 leaves wake at 0.
- R9: The pull-up output of a pin equals its pull-up request, except that it is 0 when the direction bit of that pin is 1 (output).
- R10: The pull-down output of a pin equals its pull-down request, except that it is 0 when the pin is an output or when its pull-up request is also 1.
- R11: The configuration-error output goes to 1 one edge after any pin requests both pull-up and pull-down. It then stays at 1 until reset.
- R12: The pull-up and pull-down outputs are never both 1 on the same pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running low-speed sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_i | input | 1 | High while the main clock is stopped |
| pins_i | input | N_PINS | Raw pin levels to watch |
| en_i | input | N_PINS | Per-pin change-detection enable |
| dir_out_i | input | N_PINS | Per-pin direction, 1 = digital output |
| pu_req_i | input | N_PINS | Per-pin pull-up request |
| pd_req_i | input | N_PINS | Per-pin pull-down request |
| flag_clr_i | input | 1 | One-cycle pulse that clears the flag |
| pu_o | output | N_PINS | Gated pull-up control to the pads |
| pd_o | output | N_PINS | Gated pull-down control to the pads |
| flag_o | output | 1 | Pending change interrupt request |
| wake_o | output | 1 | Wake request for a change seen in sleep |
| cfg_err_o | output | 1 | Sticky flag for a pin with both pulls requested |

## Verification
The bench builds the block with its defaults: 23 pins and a two-stage synchronizer. This lets it toggle the highest-numbered pin (22) and random masks across the full width, and measure the exact three-edge detection latency on both sides of the expected edge. Random enable masks, pin flips and pull requests are checked against bench functions. Directed cases cover a clear that coincides with a change, enables dropped while a flag is pending, and changes made inside and outside sleep.

// File: rtl/cn_pkg.sv
package cn_pkg;
    parameter int CN_DEFAULT_PINS = 23;
    parameter int CN_DEFAULT_SYNC = 2;

    function automatic int cn_cnt_width(input int limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction
endpackage

// File: rtl/cn_sync.sv
module cn_sync #(
    parameter int N_PINS      = cn_pkg::CN_DEFAULT_PINS,
    parameter int SYNC_STAGES = cn_pkg::CN_DEFAULT_SYNC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] raw_i,
    output logic [N_PINS-1:0] smp_o
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0][N_PINS-1:0] chain;
    } sync_s;

    sync_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = raw_i;
        for (int s = 1; s < SYNC_STAGES; s++) begin
            st_d.chain[s] = st_q.chain[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign smp_o = st_q.chain[SYNC_STAGES-1];
endmodule

// File: rtl/cn_detect.sv
module cn_detect #(
    parameter int N_PINS      = cn_pkg::CN_DEFAULT_PINS,
    parameter int SYNC_STAGES = cn_pkg::CN_DEFAULT_SYNC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] smp_i,
    input  logic [N_PINS-1:0] en_i,
    input  logic              clr_i,
    input  logic              sleep_i,
    output logic              flag_o,
    output logic              wake_o
);
    // Reference is valid only after the synchronizer has filled and loaded once.
    localparam int PRIME = SYNC_STAGES + 1;
    localparam int CW    = cn_pkg::cn_cnt_width(PRIME);

    typedef struct packed {
        logic [N_PINS-1:0] ref_lvl;
        logic [CW-1:0]     prime_cnt;
        logic              flag;
        logic              wake;
    } det_s;

    det_s st_d, st_q;
    logic primed;
    logic hit;

    always_comb begin
        st_d   = st_q;
        primed = (st_q.prime_cnt == CW'(PRIME));
        hit    = primed && (|((smp_i ^ st_q.ref_lvl) & en_i));
        st_d.ref_lvl = smp_i;
        if (!primed) st_d.prime_cnt = st_q.prime_cnt + 1'b1;
        st_d.flag = hit | (st_q.flag & ~clr_i);
        st_d.wake = sleep_i & (st_q.wake | hit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;
    assign wake_o = st_q.wake;

    assert_flag_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && !clr_i) |=> st_q.flag);
    assert_wake_sleep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wake |-> $past(sleep_i));
    assert_wake_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.wake) |-> st_q.flag);
    assert_no_early_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !primed |=> !$rose(st_q.flag));
endmodule

// File: rtl/cn_pull_gate.sv
module cn_pull_gate #(
    parameter int N_PINS = cn_pkg::CN_DEFAULT_PINS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] dir_out_i,
    input  logic [N_PINS-1:0] pu_req_i,
    input  logic [N_PINS-1:0] pd_req_i,
    output logic [N_PINS-1:0] pu_o,
    output logic [N_PINS-1:0] pd_o,
    output logic              cfg_err_o
);
    typedef struct packed {
        logic cfg_err;
    } pg_s;

    pg_s st_d, st_q;
    logic [N_PINS-1:0] clash;

    for (genvar p = 0; p < N_PINS; p++) begin : g_pin
        assign clash[p] = pu_req_i[p] & pd_req_i[p];
        assign pu_o[p]  = pu_req_i[p] & ~dir_out_i[p];
        assign pd_o[p]  = pd_req_i[p] & ~pu_req_i[p] & ~dir_out_i[p];
    end

    always_comb begin
        st_d = st_q;
        st_d.cfg_err = st_q.cfg_err | (|clash);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_err_o = st_q.cfg_err;

    assert_cfg_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cfg_err |=> st_q.cfg_err);
endmodule

// File: rtl/cn_notify.sv
module cn_notify #(
    parameter int N_PINS      = cn_pkg::CN_DEFAULT_PINS,
    parameter int SYNC_STAGES = cn_pkg::CN_DEFAULT_SYNC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_i,
    input  logic [N_PINS-1:0] pins_i,
    input  logic [N_PINS-1:0] en_i,
    input  logic [N_PINS-1:0] dir_out_i,
    input  logic [N_PINS-1:0] pu_req_i,
    input  logic [N_PINS-1:0] pd_req_i,
    input  logic              flag_clr_i,
    output logic [N_PINS-1:0] pu_o,
    output logic [N_PINS-1:0] pd_o,
    output logic              flag_o,
    output logic              wake_o,
    output logic              cfg_err_o
);
    logic [N_PINS-1:0] smp;

    cn_sync #(.N_PINS(N_PINS), .SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_i (pins_i),
        .smp_o (smp)
    );

    cn_detect #(.N_PINS(N_PINS), .SYNC_STAGES(SYNC_STAGES)) u_detect (
        .clk     (clk),
        .rst_n   (rst_n),
        .smp_i   (smp),
        .en_i    (en_i),
        .clr_i   (flag_clr_i),
        .sleep_i (sleep_i),
        .flag_o  (flag_o),
        .wake_o  (wake_o)
    );

    cn_pull_gate #(.N_PINS(N_PINS)) u_pull (
        .clk       (clk),
        .rst_n     (rst_n),
        .dir_out_i (dir_out_i),
        .pu_req_i  (pu_req_i),
        .pd_req_i  (pd_req_i),
        .pu_o      (pu_o),
        .pd_o      (pd_o),
        .cfg_err_o (cfg_err_o)
    );

    assert_pull_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (pu_o & pd_o) == '0);
    assert_pull_off_output_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((pu_o | pd_o) & dir_out_i) == '0);
    assert_wake_low_awake_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep_i |=> !wake_o);
endmodule

// File: tb/cn_notify_bench.sv
module cn_notify_bench;
    localparam int N  = 23;
    localparam int SS = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sleep_i = 1'b0;
    logic [N-1:0] pins_i = '0, en_i = '0, dir_out_i = '0, pu_req_i = '0, pd_req_i = '0;
    logic         flag_clr_i = 1'b0;
    logic [N-1:0] pu_o, pd_o;
    logic         flag_o, wake_o, cfg_err_o;

    int errors = 0, checks = 0;
    bit done = 1'b0;
    bit err_exp = 1'b0;

    always #10 clk = ~clk;

    cn_notify #(.N_PINS(N), .SYNC_STAGES(SS)) u_cn_notify (
        .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .pins_i(pins_i), .en_i(en_i),
        .dir_out_i(dir_out_i), .pu_req_i(pu_req_i), .pd_req_i(pd_req_i),
        .flag_clr_i(flag_clr_i), .pu_o(pu_o), .pd_o(pd_o), .flag_o(flag_o),
        .wake_o(wake_o), .cfg_err_o(cfg_err_o)
    );

    function automatic logic exp_flag(input logic [N-1:0] a, input logic [N-1:0] b,
                                      input logic [N-1:0] en);
        return |((a ^ b) & en);
    endfunction
    function automatic logic [N-1:0] exp_pu(input logic [N-1:0] pu, input logic [N-1:0] dir);
        return pu & ~dir;
    endfunction
    function automatic logic [N-1:0] exp_pd(input logic [N-1:0] pu, input logic [N-1:0] pd,
                                            input logic [N-1:0] dir);
        return pd & ~pu & ~dir;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_flag();
        flag_clr_i = 1'b1;
        tick(1);
        flag_clr_i = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        // R1: pins already high across reset release, all enabled
        pins_i = '1;
        en_i   = '1;
        tick(3);
        chk("R1 flag", N'(flag_o), '0);
        chk("R1 wake", N'(wake_o), '0);
        chk("R1 cfg_err", N'(cfg_err_o), '0);
        rst_n = 1'b1;
        tick(10);
        chk("R1 no flag from initial levels", N'(flag_o), '0);

        // R2: rising edge on highest pin, exact latency
        pins_i = '0;
        tick(10);
        clear_flag();
        en_i = '0; en_i[N-1] = 1'b1;
        pins_i[N-1] = 1'b1;
        tick(SS);
        chk("R2 not yet at SS edges", N'(flag_o), '0);
        tick(1);
        chk("R2 rise at SS+1 edges", N'(flag_o), N'(1));
        clear_flag();
        // R6: held level does not re-set
        tick(6);
        chk("R6 single event", N'(flag_o), '0);

        // R3: falling edge on pin 0
        en_i = '0; en_i[0] = 1'b1;
        pins_i[0] = 1'b1;  // pin 0 was 0; enable set with change -> rise first
        tick(SS + 1);
        clear_flag();
        tick(4);
        pins_i[0] = 1'b0;
        tick(SS);
        chk("R3 not yet at SS edges", N'(flag_o), '0);
        tick(1);
        chk("R3 fall sets flag", N'(flag_o), N'(1));

        // R7: dropping enable keeps pending flag
        en_i = '0;
        tick(3);
        chk("R7 pending flag kept", N'(flag_o), N'(1));
        // R5: hold without clear, then clear
        tick(5);
        chk("R5 flag holds", N'(flag_o), N'(1));
        clear_flag();
        chk("R5 clear", N'(flag_o), '0);

        // R4: disabled pins toggle
        pins_i = ~pins_i;
        tick(8);
        chk("R4 disabled change ignored", N'(flag_o), '0);

        // R5: change coinciding with clear keeps flag
        en_i = '1;
        pins_i[5] = ~pins_i[5];
        tick(SS + 1);
        chk("R5 flag set before collision", N'(flag_o), N'(1));
        pins_i[6] = ~pins_i[6];
        tick(SS);
        flag_clr_i = 1'b1;
        tick(1);
        flag_clr_i = 1'b0;
        chk("R5 set wins over clear", N'(flag_o), N'(1));
        clear_flag();
        chk("R5 clear after collision", N'(flag_o), '0);

        // R8: change while awake leaves wake low
        pins_i[3] = ~pins_i[3];
        tick(SS + 1);
        chk("R8 awake flag", N'(flag_o), N'(1));
        chk("R8 awake no wake", N'(wake_o), '0);
        clear_flag();
        // R8: change during sleep
        sleep_i = 1'b1;
        tick(3);
        pins_i[9] = ~pins_i[9];
        tick(SS);
        chk("R8 wake not early", N'(wake_o), '0);
        tick(1);
        chk("R8 wake with flag", N'(wake_o), N'(1));
        chk("R8 flag in sleep", N'(flag_o), N'(1));
        tick(4);
        chk("R8 wake held", N'(wake_o), N'(1));
        sleep_i = 1'b0;
        tick(1);
        chk("R8 wake drops", N'(wake_o), '0);
        clear_flag();

        // R9 R10 R11: directed pull cases
        dir_out_i = '0; pu_req_i = '0; pd_req_i = '0;
        pu_req_i[1] = 1'b1; pd_req_i[2] = 1'b1;
        pu_req_i[4] = 1'b1; pd_req_i[4] = 1'b1; dir_out_i[4] = 1'b0;
        #1;
        chk("R10 both requested gives pull-up only", pd_o, exp_pd(pu_req_i, pd_req_i, dir_out_i));
        chk("R9 pull-up pass", pu_o, exp_pu(pu_req_i, dir_out_i));
        chk("R12 exclusive", pu_o & pd_o, '0);
        tick(1);
        chk("R11 cfg_err set", N'(cfg_err_o), N'(1));
        pu_req_i = '0; pd_req_i = '0;
        tick(5);
        chk("R11 cfg_err sticky", N'(cfg_err_o), N'(1));
        err_exp = 1'b1;

        // Random: change detection (R2 R3 R4 R6) and pulls (R9 R10 R12)
        for (int it = 0; it < 60; it++) begin
            logic [N-1:0] old_p, msk;
            logic fe;
            old_p = pins_i;
            msk   = N'($urandom) & N'($urandom);
            en_i  = N'($urandom);
            pins_i = old_p ^ msk;
            fe = exp_flag(old_p, pins_i, en_i);
            dir_out_i = N'($urandom);
            pu_req_i  = N'($urandom);
            pd_req_i  = N'($urandom);
            #1;
            chk("R9 random pull-up", pu_o, exp_pu(pu_req_i, dir_out_i));
            chk("R10 random pull-down", pd_o, exp_pd(pu_req_i, pd_req_i, dir_out_i));
            chk("R12 random exclusive", pu_o & pd_o, '0);
            tick(SS + 2);
            chk(fe ? "R2 R3 random change" : "R4 random no enabled change", N'(flag_o), N'(fe));
            chk("R11 random cfg_err", N'(cfg_err_o), N'(err_exp));
            clear_flag();
            tick(2);
            chk("R6 random no repeat", N'(flag_o), '0);
        end
        finish_run();
    end
endmodule